// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital control side of a dual-slope analogue-to-digital converter. It steers the integrator input between the unknown voltage and a negative reference. It runs a counter that advances only while the comparator output is high, and it captures the final count in a result register. The integrator and the comparator are outside the block. The block sees only the comparator's one-bit decision, `comp_hi`, which is high while the integrator output is below zero.

A conversion starts with a one-cycle `start` pulse while the block is idle. The counter is cleared and the integrator is connected to the input. The sequencer then waits for the comparator to go high. The run-up phase has a fixed length: it lasts one full sweep of the counter, and the counter's rollover marks its end. At rollover the input switches to the reference and the counter starts again from zero. The run-down phase lasts as long as the comparator stays high, so its count grows with the input voltage. That count becomes the result. Two faults are caught as overrange, and each returns the sequencer to idle with an all-ones result: a comparator that never rises, and a run-down that would overflow the counter.

States: `PH_IDLE` (waiting), `PH_ARM` (input selected, waiting for the comparator), `PH_RUNUP` (fixed integration), `PH_RUNDOWN` (reference integration), `PH_LOAD` (result capture). Transitions: IDLE to ARM on `start`. ARM to RUNUP on `comp_hi`. ARM to LOAD with overrange when the arm timer expires. RUNUP to RUNDOWN on counter rollover. RUNDOWN to LOAD when `comp_hi` falls. RUNDOWN to LOAD with overrange when the counter is at its maximum and `comp_hi` is still high. LOAD to IDLE always.

Top module: `dslope_seq`

## Requirements
- R1: A `start` pulse seen in idle clears `count` to 0, selects the input (`sel_ref` = 0), clears `overrange` and raises `busy` from the next cycle.
- R2: During run-up and run-down, `count` increments by one on each clock at which `comp_hi` is 1 and holds when it is 0. While arming, `count` stays at 0.
- R3: Run-up spans 2^CNT_W counting clocks from the clock after `comp_hi` is first seen high in arm. At rollover `sel_ref` becomes 1 and `count` reads 0.
- R4: The clock after `comp_hi` is first sampled 0 in run-down, `done` and `latch_load` are high for exactly one cycle. On the following cycle `result` holds the run-down count and `busy` is 0.
- R5: With the comparator held high for m run-down clocks (0 <= m < 2^CNT_W), `result` equals m, so a larger input gives a larger code.
- R6: If `comp_hi` stays 0 for ARM_LIMIT clocks in arm, the sequencer pulses `done`, sets `overrange` and loads all ones into `result`.
- R7: If `comp_hi` is still 1 at the run-down clock where `count` is all ones (2^CNT_W run-down clocks), the sequencer ends with `overrange` set and `result` all ones.
- R8: A `start` pulse while `busy` is 1 has no effect on the phase, the counter or the result.
- R9: `result` changes only on the clock after a `latch_load` pulse. `done` never lasts two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request, honoured only while idle |
| comp_hi | input | 1 | Comparator decision, 1 while integrator output is negative |
| sel_ref | output | 1 | Integrator source select: 0 input voltage, 1 negative reference |
| count | output | CNT_W | Gated counter value |
| latch_load | output | 1 | One-cycle pulse capturing the count |
| result | output | CNT_W | Latched conversion result |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| overrange | output | 1 | Last conversion ended in overrange |

## Verification
Inputs are driven on falling edges and outputs are sampled on falling edges, so each result is read exactly one rising edge after the rising edge that produces it. `busy` and the cleared count are due at the first falling edge after `start`. `sel_ref` is due 2^CNT_W+1 falling edges after the comparator rises. `done` is due one falling edge after the comparator is lowered in run-down, and `result` and `overrange` one edge later. The bench counts falling edges to each of these points and compares the count with the arithmetic expectation. It does not poll for them.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARM,
        PH_RUNUP,
        PH_RUNDOWN,
        PH_LOAD
    } phase_t;

endpackage

// File: rtl/dslope_gate_cnt.sv
module dslope_gate_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] value,
    output logic             at_max
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign value  = cnt_q;
    assign at_max = &cnt_q;

endmodule

// File: rtl/dslope_arm_timer.sv
module dslope_arm_timer #(
    parameter int ARM_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);

    localparam int ARM_W = (ARM_LIMIT > 1) ? $clog2(ARM_LIMIT) : 1;
    localparam logic [ARM_W-1:0] LAST = ARM_W'(ARM_LIMIT - 1);

    logic [ARM_W-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (clr) begin
            tick_q <= '0;
        end else if (en && (tick_q != LAST)) begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign expired = (tick_q == LAST);

endmodule

// File: rtl/dslope_result_reg.sv
module dslope_result_reg #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             force_ones,
    input  logic [CNT_W-1:0] d,
    output logic [CNT_W-1:0] q
);

    logic [CNT_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= force_ones ? {CNT_W{1'b1}} : d;
        end
    end

    assign q = hold_q;

endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
    import dslope_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic comp_hi,
    input  logic cnt_at_max,
    input  logic arm_expired,
    output logic cnt_clr,
    output logic cnt_en,
    output logic arm_clr,
    output logic arm_en,
    output logic sel_ref,
    output logic load,
    output logic busy,
    output logic done,
    output logic ovr
);

    phase_t phase_q, phase_d;
    logic   ovr_q, ovr_d;

    // Next-phase and overrange decision
    always_comb begin
        phase_d = phase_q;
        ovr_d   = ovr_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = PH_ARM;
                    ovr_d   = 1'b0;
                end
            end
            PH_ARM: begin
                if (comp_hi) begin
                    phase_d = PH_RUNUP;
                end else if (arm_expired) begin
                    phase_d = PH_LOAD;
                    ovr_d   = 1'b1;
                end
            end
            PH_RUNUP: begin
                if (comp_hi && cnt_at_max) begin
                    phase_d = PH_RUNDOWN;
                end
            end
            PH_RUNDOWN: begin
                if (!comp_hi) begin
                    phase_d = PH_LOAD;
                end else if (cnt_at_max) begin
                    phase_d = PH_LOAD;
                    ovr_d   = 1'b1;
                end
            end
            PH_LOAD: begin
                phase_d = PH_IDLE;
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            ovr_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            ovr_q   <= ovr_d;
        end
    end

    // Output decode
    always_comb begin
        cnt_clr = 1'b0;
        cnt_en  = 1'b0;
        arm_clr = 1'b0;
        arm_en  = 1'b0;
        sel_ref = 1'b0;
        load    = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                busy    = 1'b0;
                cnt_clr = start;
                arm_clr = start;
            end
            PH_ARM: begin
                arm_en = 1'b1;
            end
            PH_RUNUP: begin
                cnt_en = comp_hi;
            end
            PH_RUNDOWN: begin
                sel_ref = 1'b1;
                cnt_en  = comp_hi;
            end
            PH_LOAD: begin
                load = 1'b1;
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign ovr = ovr_q;

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
    parameter int CNT_W     = 8,
    parameter int ARM_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             comp_hi,
    output logic             sel_ref,
    output logic [CNT_W-1:0] count,
    output logic             latch_load,
    output logic [CNT_W-1:0] result,
    output logic             busy,
    output logic             done,
    output logic             overrange
);

    logic cnt_clr, cnt_en, cnt_at_max;
    logic arm_clr, arm_en, arm_expired;

    dslope_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .comp_hi     (comp_hi),
        .cnt_at_max  (cnt_at_max),
        .arm_expired (arm_expired),
        .cnt_clr     (cnt_clr),
        .cnt_en      (cnt_en),
        .arm_clr     (arm_clr),
        .arm_en      (arm_en),
        .sel_ref     (sel_ref),
        .load        (latch_load),
        .busy        (busy),
        .done        (done),
        .ovr         (overrange)
    );

    dslope_gate_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .en     (cnt_en),
        .value  (count),
        .at_max (cnt_at_max)
    );

    dslope_arm_timer #(.ARM_LIMIT(ARM_LIMIT)) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (arm_clr),
        .en      (arm_en),
        .expired (arm_expired)
    );

    dslope_result_reg #(.CNT_W(CNT_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (latch_load),
        .force_ones (overrange),
        .d          (count),
        .q          (result)
    );

endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             comp_hi,
    input logic             sel_ref,
    input logic [CNT_W-1:0] count,
    input logic             latch_load,
    input logic [CNT_W-1:0] result,
    input logic             busy,
    input logic             done,
    input logic             overrange
);

    // R1: a new conversion begins with a cleared counter on the input
    a_r1_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (count == '0) && !sel_ref && !overrange);

    // R2: counter frozen while comparator is low during a conversion
    a_r2_hold_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !comp_hi) |=> $stable(count));

    // R3: reference selected only after rollover to zero
    a_r3_ref_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ref) |-> (count == '0));

    // R9: result moves only after a load pulse
    a_r9_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_load |=> $stable(result));

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done coincides with the load pulse
    a_r4_done_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> latch_load);

    // R6 and R7: overrange result is all ones once idle
    a_r6_ovr_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (overrange && !busy) |-> (result == {CNT_W{1'b1}}));

    // R8: a start while busy never ends the conversion early
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

bind dslope_seq dslope_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dslope_seq_test.sv
module dslope_seq_test;

    localparam int N    = 4;
    localparam int ALIM = 8;
    localparam int FULL = 1 << N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         comp_hi = 1'b0;
    logic         sel_ref;
    logic [N-1:0] count;
    logic         latch_load;
    logic [N-1:0] result;
    logic         busy;
    logic         done;
    logic         overrange;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dslope_seq #(.CNT_W(N), .ARM_LIMIT(ALIM)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .comp_hi    (comp_hi),
        .sel_ref    (sel_ref),
        .count      (count),
        .latch_load (latch_load),
        .result     (result),
        .busy       (busy),
        .done       (done),
        .overrange  (overrange)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Ramp model: run-down length m = vin * 2^N / vref, vref = 2^N
    task automatic convert(input int vin, input int arm_wait, input bit poke);
        int m;
        int k;
        int hit;
        m = (vin * FULL) / FULL;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R1 busy", busy, 1);
        check("R1 count cleared", count, 0);
        check("R1 input selected", sel_ref, 0);
        check("R1 overrange cleared", overrange, 0);
        for (int i = 0; i < arm_wait; i++) @(negedge clk);
        check("R2 count idle in arm", count, 0);
        comp_hi = 1'b1;
        k = 0;
        while (!sel_ref && k < 4 * FULL) begin
            @(negedge clk);
            k++;
            start = poke && (k == 3);
            if (k == 5) check("R2 counting", count, 4);
        end
        start = 1'b0;
        check("R3 run-up length", k, FULL + 1);
        check("R3 count restarts", count, 0);
        hit = 0;
        for (int i = 1; i <= m; i++) begin
            @(negedge clk);
            start = poke && (i == 1);
            if (done && hit == 0) hit = i;
        end
        start = 1'b0;
        comp_hi = 1'b0;
        if (m >= FULL) begin
            check("R7 overflow detect edge", hit, FULL);
        end else begin
            check("R8 no early end", busy, 1);
            @(negedge clk);
            check("R4 done one clock after fall", done, 1);
        end
        check("R4 load with done", latch_load, 1);
        @(negedge clk);
        check("R9 done single", done, 0);
        check("R4 idle after load", busy, 0);
        if (m >= FULL) begin
            check("R7 result ones", result, FULL - 1);
            check("R7 overrange", overrange, 1);
        end else begin
            check("R5 result", result, m);
            check("R5 no overrange", overrange, 0);
        end
    endtask

    task automatic arm_timeout();
        int j;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        j = 0;
        while (!done && j < 4 * ALIM) begin
            @(negedge clk);
            j++;
        end
        check("R6 timeout length", j, ALIM);
        @(negedge clk);
        check("R6 result ones", result, FULL - 1);
        check("R6 overrange", overrange, 1);
        check("R6 idle", busy, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset busy", busy, 0);
        check("R1 reset done", done, 0);
        check("R9 reset result", result, 0);
        check("R1 reset count", count, 0);
        check("R1 reset sel", sel_ref, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle stays", busy, 0);
        for (int v = 0; v < FULL; v++) convert(v, v % ALIM, (v % 3) == 0);
        convert(FULL, 2, 1'b0);
        arm_timeout();
        convert(5, ALIM - 1, 1'b1);
        // R8: an R8 stimulus in idle would start; check result held while idle
        repeat (4) @(negedge clk);
        check("R9 result held idle", result, 5);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule